// File: doc/BRIEF.md
# Flash Command Decoder with Per-Bank Read Modes

This block sits between a host bus and the storage of a multi-bank NOR-style flash. Every bus write is taken as a command cycle. Two sequences change the array, and each takes two writes. Block erase is a setup write of 20h followed by a confirm write of D0h at an address inside the target block. Word program is a setup write of 40h followed by a write that carries both the target address and the data word. The block checks the confirm code and the per-block protect flags, and only then launches its single program/erase engine. The engine is a behavioural stub: a fixed-length countdown, followed by the array update.

Every bank holds its own read mode. That mode selects what a read of any address in the bank returns:
- array words,
- the status byte,
- an identifier word,
- a query word.

A bank is switched to status mode as soon as an operation is issued to it. It stays in status mode after the operation ends, until a read-mode command arrives. While the engine works on a bank, that bank accepts only read-mode commands and the suspend code (B0h, which has no effect here). Status errors are sticky. While any error is set, new program or erase requests are refused.

The bus address is split as {bank, block, word}, with the bank in the top bits. The global block index is {bank, block}, and bit i of the protect mask guards global block i.

Top module: `flash_cmd_if`

## Requirements
- R1: A setup write of 20h followed by a D0h write starts an erase of the block addressed by the second write. A setup write of 40h followed by any write starts a program of the word and data carried by the second write. The bank's busy output rises the cycle after the second write.
- R2: If the write after a 20h setup does not carry D0h in its low byte, status bits 5 and 4 are set, the engine does not start, and the array is left unchanged.
- R3: If the second write targets a block whose protect bit is set, the engine does not start, the array is left unchanged, and status bit 1 is set. Status bit 5 is also set for an erase, or status bit 4 for a program.
- R4: The status byte is {ready(bit7), 0, eraseErr(bit5), progErr(bit4), 0, 0, protErr(bit1), 0}. Reads return it zero-extended. Ready is 0 while the engine runs. Once the second write of a sequence is taken, reads of that bank return the status byte.
- R5: After an operation ends, the bank keeps returning status until it receives FFh (array), 90h (identifier word) or 98h (query word). 70h selects status mode at any time.
- R6: While the engine works on a bank, writes to that bank other than FFh, 70h, 90h, 98h and B0h are ignored. This includes 20h, 40h, D0h and 50h.
- R7: Only one operation runs at a time. While the engine is busy, setup writes to any bank are ignored. A bank the engine is not working on serves its own read mode.
- R8: A low reset aborts a running operation and leaves the array unchanged. After reset the engine is idle, every bank is in array mode and the status byte is 80h.
- R9: A finished erase sets every word of the block to all ones. A finished program ANDs the data into the stored word.
- R10: Error bits stay set until a 50h write to a bank the engine is not working on. While any error bit is set, program and erase requests do not start the engine.
- R11: rdData and rdValid are registered, and become valid one cycle after rdEn.
- R12: A bank in array mode that the engine is not working on returns the stored word at the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; aborts an operation in flight |
| wrEn | input | 1 | One-cycle bus write strobe |
| wrAddr | input | ADDR_W (5) | Write address {bank, block, word} |
| wrData | input | DATA_W (16) | Write data; the low byte is the command code |
| rdEn | input | 1 | Read request strobe |
| rdAddr | input | ADDR_W (5) | Read address {bank, block, word} |
| protMask | input | NUM_BANKS*BLOCKS_PER_BANK (8) | Per-block protect flags, indexed by global block |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdData | output | DATA_W (16) | Array word, status byte, identifier or query word |
| bankBusy | output | NUM_BANKS (2) | The engine is working on this bank |

## Verification
The bench builds the block with its defaults: 2 banks of 4 blocks of 4 words, 16-bit data, and a 40-cycle engine. The 40-cycle engine leaves room for several command writes and reads while one bank is busy. With that window the bench covers:
- forbidden commands to the busy bank,
- a setup write to the idle bank,
- reads of the idle bank,
- a reset in the middle of an erase.

The small array lets the bench erase every block at the start, so all later expected contents are known.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_MODE_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_MODE_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] CMD_MODE_IDENT  = 8'h90;
  localparam logic [7:0] CMD_MODE_QUERY  = 8'h98;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2,
    MODE_QUERY  = 2'd3
  } readMode_e;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_ERASE = 2'd1,
    PEND_PROG  = 2'd2
  } pend_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic doErase;
  } engCmd_t;

endpackage

// File: rtl/fcu_ctrl.sv
module fcu_ctrl
  import fcu_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_W     = 1,
  parameter int GBLK_W     = 3,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int NUM_BLOCKS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_BLOCKS-1:0]         protMask,
  input  logic                          engBusy,
  input  logic [BANK_W-1:0]             engBank,
  output engCmd_t                       engCmd,
  output logic [ADDR_W-1:0]             opAddr,
  output logic [DATA_W-1:0]             opData,
  output readMode_e [NUM_BANKS-1:0]     bankMode,
  output logic [7:0]                    statusByte
);

  pend_e pend;
  logic errErase, errProg, errProt;
  logic [7:0] cmd;
  logic [BANK_W-1:0] wrBank;
  logic [GBLK_W-1:0] wrBlk;
  logic bankIsBusy, errAny, allowedBusy, clrReq;
  logic startNow, setErase, setProg, setProt;

  assign cmd        = wrData[7:0];
  assign wrBank     = wrAddr[ADDR_W-1 -: BANK_W];
  assign wrBlk      = wrAddr[ADDR_W-1 -: GBLK_W];
  assign bankIsBusy = engBusy && (engBank == wrBank);
  assign errAny     = errErase | errProg | errProt;
  assign allowedBusy = (cmd == CMD_MODE_ARRAY) || (cmd == CMD_MODE_STATUS) ||
                       (cmd == CMD_MODE_IDENT) || (cmd == CMD_MODE_QUERY) ||
                       (cmd == CMD_SUSPEND);
  assign clrReq     = wrEn && (pend == PEND_NONE) && (cmd == CMD_CLEAR_ERR);

  // second-cycle evaluation
  always_comb begin
    startNow = 1'b0;
    setErase = 1'b0;
    setProg  = 1'b0;
    setProt  = 1'b0;
    if (wrEn && pend != PEND_NONE) begin
      if (pend == PEND_ERASE && cmd != CMD_CONFIRM) begin
        setErase = 1'b1;
        setProg  = 1'b1;
      end else if (protMask[wrBlk]) begin
        setProt = 1'b1;
        if (pend == PEND_ERASE) setErase = 1'b1;
        else                    setProg  = 1'b1;
      end else if (!errAny && !engBusy) begin
        startNow = 1'b1;
      end
    end
  end

  assign engCmd.start   = startNow;
  assign engCmd.doErase = (pend == PEND_ERASE);
  assign opAddr         = wrAddr;
  assign opData         = wrData;
  assign statusByte     = {~engBusy, 1'b0, errErase, errProg, 2'b00, errProt, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= PEND_NONE;
      errErase <= 1'b0;
      errProg  <= 1'b0;
      errProt  <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) bankMode[b] <= MODE_ARRAY;
    end else if (wrEn) begin
      if (pend != PEND_NONE) begin
        pend             <= PEND_NONE;
        bankMode[wrBank] <= MODE_STATUS;
        if (setErase) errErase <= 1'b1;
        if (setProg)  errProg  <= 1'b1;
        if (setProt)  errProt  <= 1'b1;
      end else if (!engBusy && cmd == CMD_ERASE_SETUP) begin
        pend <= PEND_ERASE;
      end else if (!engBusy && cmd == CMD_PROG_SETUP) begin
        pend <= PEND_PROG;
      end else if (!bankIsBusy || allowedBusy) begin
        case (cmd)
          CMD_MODE_ARRAY:  bankMode[wrBank] <= MODE_ARRAY;
          CMD_MODE_STATUS: bankMode[wrBank] <= MODE_STATUS;
          CMD_MODE_IDENT:  bankMode[wrBank] <= MODE_IDENT;
          CMD_MODE_QUERY:  bankMode[wrBank] <= MODE_QUERY;
          CMD_CLEAR_ERR: begin
            errErase <= 1'b0;
            errProg  <= 1'b0;
            errProt  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R2: failed confirm flags both error bits and launches nothing
  assert_bad_confirm_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && pend == PEND_ERASE && wrData[7:0] != CMD_CONFIRM)
      |=> (statusByte[5] && statusByte[4] && !engBusy));

  // R3: a protected target sets the protect error and the engine stays idle
  assert_protect_abort_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && pend != PEND_NONE && protMask[wrBlk] &&
     (pend == PEND_PROG || wrData[7:0] == CMD_CONFIRM))
      |=> (statusByte[1] && !engBusy));

  // R4: the bank of a completed sequence switches to status reads
  assert_to_status_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && pend != PEND_NONE) |=> (bankMode[$past(wrBank)] == MODE_STATUS));

  // R10: errors persist without a clear request
  assert_sticky_err_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errAny && !clrReq) |=> errAny);

endmodule

// File: rtl/fcu_datapath.sv
module fcu_datapath
  import fcu_pkg::*;
#(
  parameter int NUM_BANKS       = 2,
  parameter int BANK_W          = 1,
  parameter int GBLK_W          = 3,
  parameter int WORD_W          = 2,
  parameter int ADDR_W          = 5,
  parameter int DATA_W          = 16,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int ENGINE_CYCLES   = 40,
  parameter logic [DATA_W-1:0] ID_WORD    = 16'h5A01,
  parameter logic [DATA_W-1:0] QUERY_WORD = 16'h0051
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  engCmd_t                   engCmd,
  input  logic [ADDR_W-1:0]         opAddr,
  input  logic [DATA_W-1:0]         opData,
  input  readMode_e [NUM_BANKS-1:0] bankMode,
  input  logic [7:0]                statusByte,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic                      rdValid,
  output logic [DATA_W-1:0]         rdData,
  output logic                      engBusy,
  output logic [BANK_W-1:0]         engBank,
  output logic [NUM_BANKS-1:0]      bankBusy
);

  localparam int TOTAL_WORDS = 1 << ADDR_W;
  localparam int TMR_W       = $clog2(ENGINE_CYCLES + 1);

  logic [DATA_W-1:0] mem [TOTAL_WORDS];
  logic [TMR_W-1:0]  timer;
  logic [ADDR_W-1:0] opAddrQ;
  logic [DATA_W-1:0] opDataQ;
  logic              opErase;
  logic              finish;
  logic [BANK_W-1:0] rdBank;
  logic [GBLK_W-1:0] opBlk;

  assign engBank = opAddrQ[ADDR_W-1 -: BANK_W];
  assign opBlk   = opAddrQ[ADDR_W-1 -: GBLK_W];
  assign finish  = engBusy && (timer == '0);
  assign rdBank  = rdAddr[ADDR_W-1 -: BANK_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_busy
    assign bankBusy[b] = engBusy && (engBank == BANK_W'(b));
  end

  // engine stub: countdown then array update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engBusy <= 1'b0;
      timer   <= '0;
      opAddrQ <= '0;
      opDataQ <= '0;
      opErase <= 1'b0;
    end else if (engCmd.start) begin
      engBusy <= 1'b1;
      timer   <= TMR_W'(ENGINE_CYCLES - 1);
      opAddrQ <= opAddr;
      opDataQ <= opData;
      opErase <= engCmd.doErase;
    end else if (finish) begin
      engBusy <= 1'b0;
    end else if (engBusy) begin
      timer <= timer - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (finish) begin
      if (opErase) begin
        for (int w = 0; w < WORDS_PER_BLOCK; w++)
          mem[{opBlk, WORD_W'(w)}] <= '1;
      end else begin
        mem[opAddrQ] <= mem[opAddrQ] & opDataQ;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) begin
        if (bankBusy[rdBank]) begin
          rdData <= {{(DATA_W-8){1'b0}}, statusByte};
        end else begin
          case (bankMode[rdBank])
            MODE_ARRAY:  rdData <= mem[rdAddr];
            MODE_STATUS: rdData <= {{(DATA_W-8){1'b0}}, statusByte};
            MODE_IDENT:  rdData <= ID_WORD;
            default:     rdData <= QUERY_WORD;
          endcase
        end
      end
    end
  end

  // R7: a start never overlaps a running operation
  assert_single_engine_R7: assert property (@(posedge clk) disable iff (!rstN)
    engCmd.start |-> !engBusy);

  // R1: a launched operation shows as busy on the next cycle
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    engCmd.start |=> engBusy);

  // R11: read data follows the request by one cycle
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fcu_pkg::*;
#(
  parameter int NUM_BANKS       = 2,
  parameter int BLOCKS_PER_BANK = 4,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int DATA_W          = 16,
  parameter int ENGINE_CYCLES   = 40,
  parameter logic [DATA_W-1:0] ID_WORD    = 16'h5A01,
  parameter logic [DATA_W-1:0] QUERY_WORD = 16'h0051,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int BLK_W      = $clog2(BLOCKS_PER_BANK),
  localparam int WORD_W     = $clog2(WORDS_PER_BLOCK),
  localparam int GBLK_W     = BANK_W + BLK_W,
  localparam int ADDR_W     = GBLK_W + WORD_W,
  localparam int NUM_BLOCKS = NUM_BANKS * BLOCKS_PER_BANK
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [NUM_BLOCKS-1:0] protMask,
  output logic                  rdValid,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_BANKS-1:0]  bankBusy
);

  engCmd_t                   engCmd;
  logic [ADDR_W-1:0]         opAddr;
  logic [DATA_W-1:0]         opData;
  readMode_e [NUM_BANKS-1:0] bankMode;
  logic [7:0]                statusByte;
  logic                      engBusy;
  logic [BANK_W-1:0]         engBank;

  fcu_ctrl #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .GBLK_W(GBLK_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BLOCKS(NUM_BLOCKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .protMask(protMask), .engBusy(engBusy), .engBank(engBank),
    .engCmd(engCmd), .opAddr(opAddr), .opData(opData),
    .bankMode(bankMode), .statusByte(statusByte)
  );

  fcu_datapath #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .GBLK_W(GBLK_W), .WORD_W(WORD_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
    .ENGINE_CYCLES(ENGINE_CYCLES), .ID_WORD(ID_WORD), .QUERY_WORD(QUERY_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .engCmd(engCmd), .opAddr(opAddr), .opData(opData),
    .bankMode(bankMode), .statusByte(statusByte), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .engBusy(engBusy), .engBank(engBank),
    .bankBusy(bankBusy)
  );

endmodule

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [4:0]  rdAddr = '0;
  logic [7:0]  protMask = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic [1:0]  bankBusy;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_if u_flash_cmd_if (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .protMask(protMask),
    .rdValid(rdValid), .rdData(rdData), .bankBusy(bankBusy)
  );

  function automatic logic [4:0] mk(input int bank, input int blk, input int word);
    return {bank[0], blk[1:0], word[1:0]};
  endfunction

  task automatic checkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // driver: issue a read and push its expected value
  task automatic doRead(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (bankBusy != 2'b00 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 1000) checkVal("R1 engine never finished", 16'(bankBusy), 16'h0);
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rdValid) begin
      if (expQ.size() == 0) begin
        checkVal("R11 unexpected read data", rdData, 16'hxxxx);
      end else begin
        automatic logic [15:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        checkVal(t, rdData, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R8 reset rdValid low", 16'(rdValid), 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R8 reset busy low", 16'(bankBusy), 16'h0);

    // R11: exact one-cycle latency
    busWrite(mk(0,0,0), 16'h0070);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = mk(0,0,0);
    expQ.push_back(16'h0080); tagQ.push_back("R8 status after reset");
    @(negedge clk);
    rdEn = 1'b0;
    checkVal("R11 rdValid one cycle later", 16'(rdValid), 16'h1);
    busWrite(mk(0,0,0), 16'h00FF);

    // R1/R9: erase every block
    for (int bk = 0; bk < 2; bk++) begin
      for (int bl = 0; bl < 4; bl++) begin
        busWrite(mk(bk,bl,0), 16'h0020);
        busWrite(mk(bk,bl,0), 16'h00D0);
        if (bk == 0 && bl == 0) begin
          checkVal("R1 busy after erase confirm", 16'(bankBusy), 16'h1);
          doRead(mk(0,2,3), 16'h0000, "R4 status while busy");
        end
        waitIdle();
      end
    end
    doRead(mk(1,3,0), 16'h0080, "R5 status sticks after erase");
    busWrite(mk(0,0,0), 16'h00FF);
    busWrite(mk(1,0,0), 16'h00FF);
    doRead(mk(0,1,3), 16'hFFFF, "R9 erased word");
    doRead(mk(1,3,2), 16'hFFFF, "R9 erased word bank1");

    // program and AND behaviour
    busWrite(mk(0,0,1), 16'h0040);
    busWrite(mk(0,0,1), 16'h1234);
    waitIdle();
    doRead(mk(0,0,1), 16'h0080, "R5 status after program");
    busWrite(mk(0,0,0), 16'h00FF);
    doRead(mk(0,0,1), 16'h1234, "R1 programmed word");
    busWrite(mk(0,0,1), 16'h0040);
    busWrite(mk(0,0,1), 16'hFF00);
    waitIdle();
    busWrite(mk(0,0,0), 16'h00FF);
    doRead(mk(0,0,1), 16'h1200, "R9 program ANDs");
    doRead(mk(0,0,0), 16'hFFFF, "R12 array read idle bank");

    // identifier and query modes
    busWrite(mk(0,0,0), 16'h0090);
    doRead(mk(0,2,1), 16'h5A01, "R5 identifier word");
    busWrite(mk(0,0,0), 16'h0098);
    doRead(mk(0,2,1), 16'h0051, "R5 query word");
    busWrite(mk(0,0,0), 16'h00FF);

    // bad confirm
    busWrite(mk(1,0,0), 16'h0020);
    busWrite(mk(1,0,0), 16'h00AA);
    checkVal("R2 engine not started", 16'(bankBusy), 16'h0);
    doRead(mk(1,0,0), 16'h00B0, "R2 status bits 5 and 4");
    busWrite(mk(1,0,0), 16'h00FF);
    doRead(mk(1,0,0), 16'hFFFF, "R2 array untouched");

    // requests refused while errors set
    busWrite(mk(1,1,0), 16'h0040);
    busWrite(mk(1,1,0), 16'h0000);
    checkVal("R10 program refused", 16'(bankBusy), 16'h0);
    doRead(mk(1,1,0), 16'h00B0, "R10 errors sticky");
    busWrite(mk(1,0,0), 16'h00FF);
    doRead(mk(1,1,0), 16'hFFFF, "R10 word unchanged");
    busWrite(mk(1,0,0), 16'h0050);
    busWrite(mk(1,0,0), 16'h0070);
    doRead(mk(1,0,0), 16'h0080, "R10 clear status");
    busWrite(mk(1,0,0), 16'h00FF);

    // protected block
    busWrite(mk(1,2,0), 16'h0040);
    busWrite(mk(1,2,0), 16'h00F0);
    waitIdle();
    protMask = 8'b0100_0000;
    busWrite(mk(1,2,0), 16'h0020);
    busWrite(mk(1,2,0), 16'h00D0);
    checkVal("R3 erase of protected block not started", 16'(bankBusy), 16'h0);
    doRead(mk(1,2,0), 16'h00A2, "R3 erase protect status");
    busWrite(mk(1,0,0), 16'h00FF);
    doRead(mk(1,2,0), 16'h00F0, "R3 protected data kept");
    busWrite(mk(1,0,0), 16'h0050);
    busWrite(mk(1,2,1), 16'h0040);
    busWrite(mk(1,2,1), 16'h0000);
    doRead(mk(1,2,1), 16'h0092, "R3 program protect status");
    busWrite(mk(1,0,0), 16'h0050);
    busWrite(mk(1,0,0), 16'h00FF);
    doRead(mk(1,2,1), 16'hFFFF, "R3 protected word kept");
    protMask = 8'h00;

    // whitelist while busy
    busWrite(mk(0,2,0), 16'h0040);
    busWrite(mk(0,2,0), 16'h0F0F);
    waitIdle();
    busWrite(mk(0,3,0), 16'h0040);
    busWrite(mk(0,3,0), 16'h0000);
    waitIdle();
    busWrite(mk(0,0,0), 16'h00FF);
    busWrite(mk(0,3,0), 16'h0020);
    busWrite(mk(0,3,0), 16'h00D0);
    busWrite(mk(0,2,0), 16'h0020);
    busWrite(mk(0,2,0), 16'h00D0);
    busWrite(mk(1,0,0), 16'h0040);
    busWrite(mk(1,0,0), 16'h0000);
    checkVal("R7 only bank0 busy", 16'(bankBusy), 16'h1);
    doRead(mk(1,0,0), 16'hFFFF, "R7 R12 idle bank serves array");
    busWrite(mk(0,0,0), 16'h00FF);
    doRead(mk(0,0,0), 16'h0000, "R6 busy bank returns status");
    waitIdle();
    doRead(mk(0,2,0), 16'h0F0F, "R6 forbidden erase ignored");
    doRead(mk(0,3,0), 16'hFFFF, "R9 erase after whitelist");
    doRead(mk(1,0,0), 16'hFFFF, "R7 ignored setup on idle bank");
    busWrite(mk(0,0,0), 16'h0070);
    doRead(mk(0,0,0), 16'h0080, "R6 no error from ignored writes");

    // reset in the middle of an erase
    busWrite(mk(1,3,2), 16'h0040);
    busWrite(mk(1,3,2), 16'h3C3C);
    waitIdle();
    busWrite(mk(1,3,0), 16'h0020);
    busWrite(mk(1,3,0), 16'h00D0);
    repeat (5) @(negedge clk);
    checkVal("R8 erase running before reset", 16'(bankBusy), 16'h2);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R8 engine idle after reset", 16'(bankBusy), 16'h0);
    doRead(mk(1,3,2), 16'h3C3C, "R8 aborted erase left data");
    busWrite(mk(1,0,0), 16'h0070);
    doRead(mk(1,0,0), 16'h0080, "R8 status after abort");

    repeat (5) @(negedge clk);
    checkVal("R11 all reads answered", 16'(expQ.size()), 16'h0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule